// File: doc/BRIEF.md
# Epoch-Based Memory Bus Level Selector

This block watches the data beats moving on a single memory channel and, once per measurement epoch, chooses one of three bus operating points for that channel. A channel that carries little traffic is moved to a slower bus clock, which also allows a lower supply voltage. A channel that carries heavy traffic is kept at the fastest point. One instance serves one channel, so each channel is measured and steered on its own.

The epoch length and the two traffic thresholds are inputs. At the last cycle of each epoch the beat total is compared against the two thresholds and a level is selected. If that level differs from the level in force, a one-cycle change request carrying the target level is sent to an external transition sequencer. The level in force is updated only when the sequencer acknowledges. Clock generation, voltage regulation and DRAM command issue belong to the sequencer and are not part of this block. `rst_n` is asserted asynchronously. The reset controller upstream releases it synchronously to `clk`.

Top module: `bwgov_top`

## Requirements
- R1: An epoch lasts `epoch_len` clock cycles, with a value of 0 treated as 1. The first epoch starts in the first cycle after reset release. A decision is taken only in the last cycle of an epoch, so `chg_req` never rises from within an epoch.
- R2: The traffic total for an epoch counts one for each cycle with `beat_valid` high, including the epoch's last cycle. The count restarts from zero for the next epoch.
- R3: The beat count saturates at its all-ones value (2^CNT_W - 1) and does not wrap.
- R4: The level codes are: 0 = slowest bus point (lowest voltage), 1 = middle point, 2 = fastest point (highest voltage). A total strictly below `thr_low` selects code 0.
- R5: Otherwise, a total strictly below `thr_mid` selects code 1, and any other total selects code 2. The thresholds used are the values present in the epoch's last cycle.
- R6: When `thr_low` >= `thr_mid`, code 1 is never selected.
- R7: During and after reset, `cur_level` is 2 and `chg_req` is 0.
- R8: `chg_req` is high for exactly one cycle, in the cycle after the decision, and only when the selected code differs from `cur_level`. `chg_level` then carries the selected code.
- R9: After a request, `cur_level` takes the target code in the cycle after `seq_ack` is seen. Until that acknowledge arrives, no further request is issued and `cur_level` holds.
- R10: A decision that falls in a cycle with `seq_busy` high is dropped. No request is issued and `cur_level` is unchanged.
- R11: Code 3 never appears on `cur_level` or `chg_level`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| epoch_len | input | EPOCH_W | Epoch length in cycles (0 acts as 1) |
| thr_low | input | CNT_W | Total below this selects the slowest point |
| thr_mid | input | CNT_W | Total below this (and not below thr_low) selects the middle point |
| beat_valid | input | 1 | One data beat moved on the channel this cycle |
| seq_busy | input | 1 | Transition sequencer busy; decisions are dropped |
| seq_ack | input | 1 | Sequencer completed the requested change |
| chg_req | output | 1 | One-cycle level change request |
| chg_level | output | 2 | Target level code of the request |
| cur_level | output | 2 | Level code currently in force |

## Verification
Two functions can act in the same cycle. The first is the epoch-end decision, which clears the counter and compares the thresholds. The second is the beat that arrives in that same last cycle. The bench places beats right up to the final cycle and uses totals that sit exactly on a threshold, so a last beat that is lost or counted twice moves the selected code. The decision can also coincide with a busy sequencer or with a pending acknowledge. The bench raises `seq_busy` only in the epoch's last cycle and leaves requests unacknowledged across boundaries, then judges the outcome from `chg_req` and `cur_level` in the following cycles.

// File: rtl/bwgov_pkg.sv
package bwgov_pkg;
  // Operating point codes; code 3 is reserved
  typedef enum logic [1:0] {
    LVL_SLOW = 2'd0,
    LVL_MID  = 2'd1,
    LVL_FAST = 2'd2
  } lvl_e;
endpackage

// File: rtl/bwgov_epoch_timer.sv
module bwgov_epoch_timer #(
  parameter int EPOCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EPOCH_W-1:0] epoch_len,
  output logic               epoch_end
);
  logic [EPOCH_W-1:0] tmr_q, tmr_d, last_idx;

  always_comb begin
    last_idx  = (epoch_len == '0) ? '0 : epoch_len - 1'b1;
    epoch_end = (tmr_q >= last_idx);
    tmr_d     = epoch_end ? '0 : tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  // R1
  restart_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_end |=> (tmr_q == '0));
endmodule

// File: rtl/bwgov_beat_counter.sv
module bwgov_beat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             clr,
  output logic [CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             inc_en;

  always_comb begin
    inc_en = beat_valid && (cnt_q != CNT_MAX);
    total  = inc_en ? cnt_q + 1'b1 : cnt_q;
    cnt_d  = clr ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/bwgov_level_pick.sv
module bwgov_level_pick
  import bwgov_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] thr_low,
  input  logic [CNT_W-1:0] thr_mid,
  output lvl_e             sel
);
  always_comb begin
    if (total < thr_low)      sel = LVL_SLOW;
    else if (total < thr_mid) sel = LVL_MID;
    else                      sel = LVL_FAST;
  end
endmodule

// File: rtl/bwgov_handshake.sv
module bwgov_handshake
  import bwgov_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic epoch_end,
  input  lvl_e sel,
  input  logic seq_busy,
  input  logic seq_ack,
  output logic req,
  output lvl_e tgt,
  output lvl_e cur
);
  logic wait_q, wait_d, req_d, go, done;
  lvl_e tgt_q, tgt_d, cur_q, cur_d;

  always_comb begin
    go     = epoch_end && !wait_q && !seq_busy && (sel != cur_q);
    done   = wait_q && seq_ack;
    req_d  = go;
    tgt_d  = go ? sel : tgt_q;
    cur_d  = done ? tgt_q : cur_q;
    wait_d = go ? 1'b1 : (done ? 1'b0 : wait_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      req    <= 1'b0;
      tgt_q  <= LVL_FAST;
      cur_q  <= LVL_FAST;
    end else begin
      wait_q <= wait_d;
      req    <= req_d;
      tgt_q  <= tgt_d;
      cur_q  <= cur_d;
    end
  end

  assign tgt = tgt_q;
  assign cur = cur_q;

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R8
  req_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (tgt_q != cur_q));
  // R9
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ack |=> $stable(cur_q));
  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_end && seq_busy) |=> !req);
  // R11
  lvl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != lvl_e'(2'd3)) && (tgt_q != lvl_e'(2'd3)));
endmodule

// File: rtl/bwgov_top.sv
module bwgov_top
  import bwgov_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int EPOCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EPOCH_W-1:0] epoch_len,
  input  logic [CNT_W-1:0]   thr_low,
  input  logic [CNT_W-1:0]   thr_mid,
  input  logic               beat_valid,
  input  logic               seq_busy,
  input  logic               seq_ack,
  output logic               chg_req,
  output logic [1:0]         chg_level,
  output logic [1:0]         cur_level
);
  logic             epoch_end;
  logic [CNT_W-1:0] total;
  lvl_e             sel, tgt, cur;

  bwgov_epoch_timer #(.EPOCH_W(EPOCH_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .epoch_len(epoch_len), .epoch_end(epoch_end)
  );

  bwgov_beat_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .clr(epoch_end),
    .total(total)
  );

  bwgov_level_pick #(.CNT_W(CNT_W)) pick_i (
    .total(total), .thr_low(thr_low), .thr_mid(thr_mid), .sel(sel)
  );

  bwgov_handshake hs_i (
    .clk(clk), .rst_n(rst_n), .epoch_end(epoch_end), .sel(sel),
    .seq_busy(seq_busy), .seq_ack(seq_ack),
    .req(chg_req), .tgt(tgt), .cur(cur)
  );

  assign chg_level = tgt;
  assign cur_level = cur;

  // R1
  req_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_req |-> $past(epoch_end));
  // R6
  no_mid_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_end && thr_low >= thr_mid) |-> (sel != LVL_MID));
endmodule

// File: tb/bwgov_top_tb_top.sv
`timescale 1ns/1ps
module bwgov_top_tb_top;
  localparam int CW = 5;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [EW-1:0] epoch_len;
  logic [CW-1:0] thr_low, thr_mid;
  logic          beat_valid, seq_busy, seq_ack;
  logic          chg_req;
  logic [1:0]    chg_level, cur_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bwgov_top #(.CNT_W(CW), .EPOCH_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .epoch_len(epoch_len), .thr_low(thr_low),
    .thr_mid(thr_mid), .beat_valid(beat_valid), .seq_busy(seq_busy),
    .seq_ack(seq_ack), .chg_req(chg_req), .chg_level(chg_level),
    .cur_level(cur_level)
  );

  // {thr_low, thr_mid, beats, expected level}, epoch of 32 cycles
  localparam int NV = 10;
  localparam int VEC [NV][4] = '{
    '{10, 20,  5, 0}, '{10, 20, 10, 1}, '{10, 20, 19, 1}, '{10, 20, 20, 2},
    '{10, 20, 32, 2}, '{20, 10, 15, 0}, '{20, 10, 25, 2}, '{ 0,  0,  0, 2},
    '{ 1,  5,  0, 0}, '{ 0, 31, 30, 1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int elen, input int tl, input int tm);
    rst_n = 1'b0; beat_valid = 1'b0; seq_busy = 1'b0; seq_ack = 1'b0;
    epoch_len = EW'(elen); thr_low = CW'(tl); thr_mid = CW'(tm);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Runs one epoch of len cycles; returns at the negedge after its last edge
  task automatic run_epoch(input int len, input int beats, input bit ack_early,
                           input bit busy_end, input bit thr_chg,
                           input int nl, input int nm);
    int early = 0;
    for (int i = 0; i < len; i++) begin
      beat_valid = (i < beats);
      seq_ack    = ack_early && (i == 1);
      seq_busy   = busy_end && (i == len - 1);
      if (thr_chg && i == len - 2) begin
        thr_low = CW'(nl); thr_mid = CW'(nm);
      end
      @(negedge clk);
      if (i < len - 1 && chg_req) early++;
    end
    beat_valid = 1'b0; seq_ack = 1'b0; seq_busy = 1'b0;
    chk("R1 no request inside epoch", early, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    rst_n = 1'b0; beat_valid = 1'b0; seq_busy = 1'b0; seq_ack = 1'b0;
    epoch_len = 8'd32; thr_low = 5'd10; thr_mid = 5'd20;
    repeat (2) @(negedge clk);
    chk("R7 cur_level in reset", int'(cur_level), 2);
    chk("R7 chg_req in reset", int'(chg_req), 0);

    // Table walk: R4 R5 R6 R8 R9
    for (int v = 0; v < NV; v++) begin
      int lv;
      lv = VEC[v][3];
      do_reset(32, VEC[v][0], VEC[v][1]);
      run_epoch(32, VEC[v][2], 1'b0, 1'b0, 1'b0, 0, 0);
      chk($sformatf("R4/R5 vec%0d request", v), int'(chg_req), (lv != 2) ? 1 : 0);
      if (lv != 2) chk($sformatf("R8 vec%0d target", v), int'(chg_level), lv);
      seq_ack = 1'b1;
      @(negedge clk);
      seq_ack = 1'b0;
      chk($sformatf("R8 vec%0d pulse ended", v), int'(chg_req), 0);
      chk($sformatf("R9 vec%0d cur_level", v), int'(cur_level), lv);
    end

    // R2 counter restarts each epoch
    do_reset(32, 10, 20);
    run_epoch(32, 15, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R2 first epoch target", int'(chg_level), 1);
    run_epoch(32, 5, 1'b1, 1'b0, 1'b0, 0, 0);
    chk("R2 second epoch request", int'(chg_req), 1);
    chk("R2 second epoch target", int'(chg_level), 0);

    // R9 no new request while awaiting acknowledge
    do_reset(32, 10, 20);
    run_epoch(32, 5, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R9 initial request", int'(chg_req), 1);
    run_epoch(32, 15, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R9 suppressed while pending", int'(chg_req), 0);
    chk("R9 cur held while pending", int'(cur_level), 2);
    run_epoch(32, 15, 1'b1, 1'b0, 1'b0, 0, 0);
    chk("R9 cur after ack", int'(cur_level), 0);
    chk("R9 request after ack", int'(chg_req), 1);
    chk("R9 target after ack", int'(chg_level), 1);

    // R10 busy at decision drops it
    run_epoch(32, 30, 1'b1, 1'b1, 1'b0, 0, 0);
    chk("R10 busy drops request", int'(chg_req), 0);
    chk("R10 cur unchanged", int'(cur_level), 1);
    run_epoch(32, 30, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R10 request once idle", int'(chg_req), 1);
    chk("R10 target once idle", int'(chg_level), 2);

    // R3 saturation: 40 beats with 5-bit counter stay at 31
    do_reset(40, 10, 31);
    run_epoch(40, 40, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R3 saturated total keeps fast level", int'(chg_req), 0);
    chk("R3 cur_level", int'(cur_level), 2);

    // R5 thresholds taken from the last cycle
    do_reset(32, 30, 31);
    run_epoch(32, 15, 1'b0, 1'b0, 1'b1, 10, 20);
    chk("R5 late threshold request", int'(chg_req), 1);
    chk("R5 late threshold target", int'(chg_level), 1);

    // R1 epoch_len of zero behaves as one cycle
    do_reset(0, 1, 5);
    run_epoch(1, 0, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R1 single-cycle epoch request", int'(chg_req), 1);
    chk("R1 single-cycle epoch target", int'(chg_level), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule